// File: doc/BRIEF.md
# Batch Bitstream Byte Aligner

This block takes a batch of variable-length coded macroblock bitstreams, each given with its length in bits, and turns them into a byte-aligned output stream. Each macroblock yields one output segment of whole bytes. Any bits left over at the end of a macroblock (fewer than eight) are moved to the front of the next macroblock's first byte. The next macroblock's bits are shifted right by the same number of positions.

Every shift amount in a batch comes from the lengths alone, through a running sum taken modulo 8. All macroblocks of a batch are therefore aligned in the same cycle by parallel aligner slices. The segments are then sent out one per cycle, in macroblock order, over a valid/ready handshake. The residue of the last macroblock is kept and goes in front of the first macroblock of the next batch. A flush request turns any pending residue into one final byte, padded with zeros.

Top module: `bp_batch_packer`

## Requirements
- R1: Macroblock i sits in `in_data[i*MAXB +: MAXB]` and its length in `in_len[i*LW +: LW]`, with 0 <= length <= MAXB. Its bits are read starting at bit MAXB-1. Only the top `length` bits are used, and any bits below them have no effect on the output.
- R2: The bit offset of macroblock i is c_i. c_0 is the residue count held from earlier batches, and c_(i+1) = (c_i + L_i) mod 8. The segment of macroblock i starts with the c_i residue bits and then continues with its own bits.
- R3: A segment carries floor((c_i + L_i) / 8) bytes in `out_nbytes`. The bytes sit left-aligned in `out_data`, first byte in bits [8*OB-1 -: 8], and all bytes beyond the count read as zero.
- R4: The residue bits of the last macroblock in a batch are kept. They lead the first macroblock of the next accepted batch.
- R5: A batch of `in_count` macroblocks (1..NMB) gives exactly `in_count` segments, in macroblock order. After the last one `out_valid` falls and `in_ready` rises.
- R6: A batch or flush is taken only on a cycle with `in_ready` high, and `in_ready` is low while any segment is waiting. While `out_valid` is high and `out_ready` is low, `out_data` and `out_nbytes` hold steady.
- R7: A flush alone (`in_flush` high, `in_valid` low) with a non-zero residue gives one segment of 1 byte. That byte has the residue bits at its top and zeros below, and the residue is then cleared. With a zero residue, a flush gives no segment.
- R8: A flush taken in the same cycle as a batch gives the batch's segments first. It then gives one more 1-byte segment with the batch's final residue, if that residue is non-zero, and leaves the residue cleared.
- R9: After reset `out_valid` is low, `in_ready` is high and the residue is empty.
- R10: A macroblock whose bits, together with its carry-in, do not complete a byte still gives a segment, with `out_nbytes` = 0. Its bits pass on in the residue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Batch present |
| in_ready | output | 1 | Block can take a batch or flush |
| in_count | input | CW | Macroblocks in the batch |
| in_flush | input | 1 | Emit the residue as a padded byte |
| in_data | input | NMB*MAXB | Macroblock bitstreams, MSB-first |
| in_len | input | NMB*LW | Macroblock lengths in bits |
| out_valid | output | 1 | Segment present |
| out_ready | input | 1 | Consumer takes segment |
| out_data | output | 8*OB | Aligned segment bytes, left-aligned |
| out_nbytes | output | NBW | Valid bytes in the segment |

## Verification
A batch and a flush can be taken in the same cycle. The final residue of the batch must then come out as an extra padded byte after the batch's last segment, not be carried on. The bench provokes this with a one-macroblock batch of 13 bits and the flush raised together. It checks that a second segment of one byte follows, holding the 5 leftover bits. It then checks that the next batch starts at offset zero. The same bench model also judges flushes given alone, both with a residue and with none.

// File: rtl/bp_pkg.sv
package bp_pkg;
    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_SEND = 1'b1
    } bp_phase_e;
endpackage

// File: rtl/bp_prefix.sv
// Running bit offset of every macroblock, modulo 8, from the lengths only.
module bp_prefix #(
    parameter int NMB = 4,
    parameter int LW  = 6
) (
    input  logic [2:0]          carry_i,
    input  logic [NMB*LW-1:0]   len_i,
    output logic [NMB:0][2:0]   off_o
);
    always_comb begin
        logic [2:0] acc;
        acc      = carry_i;
        off_o[0] = acc;
        for (int i = 0; i < NMB; i++) begin
            acc        = acc + len_i[i*LW +: 3];
            off_o[i+1] = acc;
        end
    end
endmodule

// File: rtl/bp_align.sv
// One aligner slice: prepends the incoming residue, shifts the macroblock
// by its offset, cuts whole bytes and hands the tail to the next slice.
module bp_align #(
    parameter int MAXB = 32,
    parameter int LW   = 6,
    parameter int OB   = 4,
    parameter int NBW  = 3
) (
    input  logic [MAXB-1:0]  data_i,
    input  logic [LW-1:0]    len_i,
    input  logic [2:0]       off_i,
    input  logic [7:0]       rtop_i,
    output logic [OB*8-1:0]  seg_o,
    output logic [NBW-1:0]   nbytes_o,
    output logic [7:0]       rtop_o
);
    localparam int W = MAXB + 8;

    logic [MAXB-1:0] used_mask;
    logic [MAXB-1:0] data_m;
    logic [W-1:0]    ext;
    logic [W-1:0]    kept;
    logic [W-1:0]    tail;
    logic [LW:0]     total;
    logic [LW-3:0]   nb;

    always_comb begin
        used_mask = ~({MAXB{1'b1}} >> len_i);
        data_m    = data_i & used_mask;
        ext       = {rtop_i, {MAXB{1'b0}}} | ({data_m, 8'b0} >> off_i);
        total     = {1'b0, len_i} + {{(LW-2){1'b0}}, off_i};
        nb        = total[LW:3];
        kept      = ext & ~({W{1'b1}} >> {nb, 3'b000});
        tail      = ext << {nb, 3'b000};
        seg_o     = kept[W-1 -: OB*8];
        nbytes_o  = NBW'(nb);
        rtop_o    = tail[W-1 -: 8];
    end
endmodule

// File: rtl/bp_batch_packer.sv
module bp_batch_packer #(
    parameter int NMB  = 4,
    parameter int MAXB = 32,
    localparam int LW  = $clog2(MAXB + 1),
    localparam int OB  = (MAXB + 7) / 8,
    localparam int NBW = $clog2(OB + 1),
    localparam int CW  = $clog2(NMB + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    output logic                 in_ready,
    input  logic [CW-1:0]        in_count,
    input  logic                 in_flush,
    input  logic [NMB*MAXB-1:0]  in_data,
    input  logic [NMB*LW-1:0]    in_len,
    output logic                 out_valid,
    input  logic                 out_ready,
    output logic [OB*8-1:0]      out_data,
    output logic [NBW-1:0]       out_nbytes
);
    import bp_pkg::*;

    localparam int NS = NMB + 1;

    typedef struct packed {
        bp_phase_e                   phase;
        logic [CW-1:0]               idx;
        logic [CW-1:0]               total;
        logic [2:0]                  carry;
        logic [7:0]                  resid;
        logic [NS-1:0][OB*8-1:0]     seg;
        logic [NS-1:0][NBW-1:0]      nb;
    } st_t;

    st_t st_d, st_q;

    logic [NMB:0][2:0]           offs;
    logic [NMB:0][7:0]           rchain;
    logic [NMB-1:0][OB*8-1:0]    seg_w;
    logic [NMB-1:0][NBW-1:0]     nb_w;

    bp_prefix #(.NMB(NMB), .LW(LW)) u_prefix (
        .carry_i (st_q.carry),
        .len_i   (in_len),
        .off_o   (offs)
    );

    assign rchain[0] = st_q.resid;

    for (genvar g = 0; g < NMB; g++) begin : g_slice
        bp_align #(.MAXB(MAXB), .LW(LW), .OB(OB), .NBW(NBW)) u_align (
            .data_i   (in_data[g*MAXB +: MAXB]),
            .len_i    (in_len[g*LW +: LW]),
            .off_i    (offs[g]),
            .rtop_i   (rchain[g]),
            .seg_o    (seg_w[g]),
            .nbytes_o (nb_w[g]),
            .rtop_o   (rchain[g+1])
        );
    end

    always_comb begin
        logic [CW-1:0] cnt;
        logic [CW-1:0] tot;
        logic [2:0]    fin_off;
        logic [7:0]    fin_res;

        st_d    = st_q;
        cnt     = '0;
        tot     = '0;
        fin_off = '0;
        fin_res = '0;

        if (st_q.phase == PH_IDLE) begin
            if (in_valid || in_flush) begin
                if (in_valid)
                    cnt = (in_count > CW'(NMB)) ? CW'(NMB) : in_count;
                fin_off = offs[cnt];
                fin_res = rchain[cnt];
                for (int k = 0; k < NMB; k++) begin
                    st_d.seg[k] = seg_w[k];
                    st_d.nb[k]  = nb_w[k];
                end
                tot = cnt;
                if (in_flush) begin
                    if (fin_off != 3'd0) begin
                        st_d.seg[cnt] = {fin_res, {(OB*8-8){1'b0}}};
                        st_d.nb[cnt]  = NBW'(1);
                        tot           = cnt + CW'(1);
                    end
                    st_d.carry = '0;
                    st_d.resid = '0;
                end else begin
                    st_d.carry = fin_off;
                    st_d.resid = fin_res;
                end
                st_d.idx   = '0;
                st_d.total = tot;
                if (tot != '0)
                    st_d.phase = PH_SEND;
            end
        end else if (out_ready) begin
            if (st_q.idx == st_q.total - CW'(1))
                st_d.phase = PH_IDLE;
            else
                st_d.idx = st_q.idx + CW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign in_ready   = (st_q.phase == PH_IDLE);
    assign out_valid  = (st_q.phase == PH_SEND);
    assign out_data   = st_q.seg[st_q.idx];
    assign out_nbytes = st_q.nb[st_q.idx];
endmodule

// File: rtl/bp_batch_packer_chk.sv
module bp_batch_packer_chk #(
    parameter int NMB  = 4,
    parameter int MAXB = 32,
    localparam int OB  = (MAXB + 7) / 8,
    localparam int NBW = $clog2(OB + 1),
    localparam int CW  = $clog2(NMB + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             in_ready,
    input logic [CW-1:0]    in_count,
    input logic             in_flush,
    input logic             out_valid,
    input logic             out_ready,
    input logic [OB*8-1:0]  out_data,
    input logic [NBW-1:0]   out_nbytes
);
    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_nbytes)));

    p_pad_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ((out_data << {out_nbytes, 3'b000}) == '0));

    p_nbytes_max_r3: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_nbytes <= NBW'(OB)));

    p_batch_emits_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && in_count != '0) |=> out_valid);

    p_flush_one_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_flush && in_ready && !in_valid) |=> (!out_valid || out_nbytes == NBW'(1)));
endmodule

bind bp_batch_packer bp_batch_packer_chk #(.NMB(NMB), .MAXB(MAXB)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .in_count   (in_count),
    .in_flush   (in_flush),
    .out_valid  (out_valid),
    .out_ready  (out_ready),
    .out_data   (out_data),
    .out_nbytes (out_nbytes)
);

// File: tb/bp_batch_packer_tb.sv
module bp_batch_packer_tb;
    localparam int NMB  = 4;
    localparam int MAXB = 32;
    localparam int LW   = $clog2(MAXB + 1);
    localparam int OB   = (MAXB + 7) / 8;
    localparam int NBW  = $clog2(OB + 1);
    localparam int CW   = $clog2(NMB + 1);
    localparam int NV   = 6;

    // stimulus table: count, flush, lengths, data
    localparam int V_CNT [NV] = '{3, 4, 2, 1, 4, 2};
    localparam bit V_FL  [NV] = '{0, 0, 0, 1, 0, 0};
    localparam int V_LEN [NV][4] = '{
        '{18, 12, 14, 0},
        '{3, 2, 1, 0},
        '{32, 30, 0, 0},
        '{13, 0, 0, 0},
        '{31, 7, 25, 10},
        '{15, 16, 0, 0}
    };
    localparam logic [31:0] V_DAT [NV][4] = '{
        '{32'hB3C4_0000, 32'h5A50_0000, 32'hE71C_0000, 32'h0},
        '{32'hA000_0000, 32'hC000_0000, 32'h8000_0000, 32'hFFFF_FFFF},
        '{32'h1234_5678, 32'h9ABC_DEF3, 32'h0, 32'h0},
        '{32'hF5A7_FFFF, 32'h0, 32'h0, 32'h0},
        '{32'hDEAD_BEEE, 32'h6E00_0000, 32'hC0FF_EE00, 32'h8A40_0000},
        '{32'h7FFE_0000, 32'h3C5A_0000, 32'h0, 32'h0}
    };

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 in_valid = 1'b0;
    logic                 in_ready;
    logic [CW-1:0]        in_count = '0;
    logic                 in_flush = 1'b0;
    logic [NMB*MAXB-1:0]  in_data = '0;
    logic [NMB*LW-1:0]    in_len = '0;
    logic                 out_valid;
    logic                 out_ready = 1'b1;
    logic [OB*8-1:0]      out_data;
    logic [NBW-1:0]       out_nbytes;

    int checks = 0;
    int errors = 0;

    longint m_rv = 0;
    int     m_rc = 0;
    longint exp_d [NMB+1];
    int     exp_n [NMB+1];
    int     nexp;

    always #5 clk = ~clk;

    bp_batch_packer #(.NMB(NMB), .MAXB(MAXB)) u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_count(in_count), .in_flush(in_flush), .in_data(in_data),
        .in_len(in_len), .out_valid(out_valid), .out_ready(out_ready),
        .out_data(out_data), .out_nbytes(out_nbytes)
    );

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic string vtag(input int v);
        case (v)
            0: return "R2";
            1: return "R10";
            2: return "R1";
            3: return "R8";
            4: return "R3";
            default: return "R4";
        endcase
    endfunction

    // bit-serial reference: residue value/count, whole bytes leave per macroblock
    task automatic model(input int cnt, input bit fl, input int lens [4], input logic [31:0] dats [4]);
        nexp = 0;
        for (int k = 0; k < cnt; k++) begin
            longint acc;
            longint bits;
            int tot;
            int nb;
            int rem;
            bits = longint'(dats[k]) >> (32 - lens[k]);
            acc  = (m_rv << lens[k]) | bits;
            tot  = m_rc + lens[k];
            nb   = tot / 8;
            rem  = tot % 8;
            exp_n[nexp] = nb;
            exp_d[nexp] = (nb > 0) ? (((acc >> rem) << (32 - nb*8)) & 64'hFFFF_FFFF) : 0;
            nexp++;
            m_rv = acc & ((64'd1 << rem) - 1);
            m_rc = rem;
        end
        if (fl) begin
            if (m_rc > 0) begin
                exp_n[nexp] = 1;
                exp_d[nexp] = (m_rv << (8 - m_rc)) << 24;
                nexp++;
            end
            m_rv = 0;
            m_rc = 0;
        end
    endtask

    task automatic run(input int cnt, input bit fl, input int lens [4],
                       input logic [31:0] dats [4], input string tag, input bit stall);
        model(cnt, fl, lens, dats);
        @(negedge clk);
        in_valid = (cnt > 0);
        in_count = CW'(cnt);
        in_flush = fl;
        for (int k = 0; k < NMB; k++) begin
            in_data[k*MAXB +: MAXB] = dats[k];
            in_len[k*LW +: LW]      = LW'(lens[k]);
        end
        if (stall) out_ready = 1'b0;
        @(negedge clk);
        in_valid = 1'b0;
        in_flush = 1'b0;
        for (int k = 0; k < nexp; k++) begin
            chk(out_valid == 1'b1, {tag, " valid"}, longint'(out_valid), 1);
            chk(out_data == exp_d[k][31:0], {tag, " data"}, longint'(out_data), exp_d[k]);
            chk(out_nbytes == NBW'(exp_n[k]), {tag, " nbytes"}, longint'(out_nbytes), exp_n[k]);
            if (stall && k == 0) begin
                for (int s = 0; s < 3; s++) begin
                    @(negedge clk);
                    chk(out_valid && out_data == exp_d[0][31:0] && out_nbytes == NBW'(exp_n[0]),
                        "R6 hold under stall", longint'(out_data), exp_d[0]);
                    chk(in_ready == 1'b0, "R6 in_ready low while pending", longint'(in_ready), 0);
                end
                out_ready = 1'b1;
            end
            @(negedge clk);
        end
        chk(out_valid == 1'b0 && in_ready == 1'b1, {tag, " R5 end of segments"},
            longint'({out_valid, in_ready}), 1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int lz [4];
        logic [31:0] dz [4];
        repeat (3) @(negedge clk);
        chk(out_valid == 1'b0, "R9 out_valid after reset", longint'(out_valid), 0);
        chk(in_ready == 1'b1, "R9 in_ready after reset", longint'(in_ready), 1);
        rst_n = 1'b1;

        for (int v = 0; v < NV; v++)
            run(V_CNT[v], V_FL[v], V_LEN[v], V_DAT[v], vtag(v), 1'b0);

        // hand value for the 18/12/14 example: first segment is B3 C4 (R2)
        lz = '{18, 0, 0, 0};
        dz = '{32'hB3C4_0000, 0, 0, 0};
        // residue is zero here; zero-residue flush gives nothing (R7)
        run(0, 1'b1, lz, dz, "R7 empty flush", 1'b0);
        run(1, 1'b0, lz, dz, "R2 hand", 1'b0);
        chk(exp_d[0] == 64'hB3C4_0000, "R2 hand model", exp_d[0], 64'hB3C4_0000);
        // residue now 2 bits ('00'); add 5 bits for a 7-bit residue
        lz = '{5, 0, 0, 0};
        dz = '{32'hD800_0000, 0, 0, 0};
        run(1, 1'b0, lz, dz, "R10 short", 1'b0);
        run(0, 1'b1, lz, dz, "R7 residue flush", 1'b0);
        // stall across a two-segment batch
        lz = '{16, 16, 0, 0};
        dz = '{32'hA55A_0000, 32'h0FF0_0000, 0, 0};
        run(2, 1'b0, lz, dz, "R6 stall batch", 1'b1);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule